// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 112 active-high interrupt sources into one interrupt line. The sources are split into two master groups, each holding seven 8-bit blocks. Every block has four registers at fixed addresses, so no block-select step is needed:
- a latched-status register, which shows only unmasked pending bits;
- a write-one-to-clear register;
- a mask register;
- a live-level register.

Each master has a summary byte at its base address, with one bit for each of its blocks. Bit 0 of master 0's summary shows whether master 1 has anything pending. A handler reads master 0's summary first and reads master 1's summary only when bit 0 is set.

A source latches when its synchronised input rises. Reset masks every source. Software unmasks blocks through the register bus, which has a 16-bit address and 8-bit data. The bus returns read data registered, one cycle after the address is presented.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, every mask register reads 0xFF and every latched-status register reads 0x00.
- R2: A rising edge on an input latches that source's pending bit. When the source is unmasked, `irq_o` is 1 no later than four clock edges after the first edge that samples the input high.
- R3: Register addresses are base + k + offset. The base is 0x130 for master 0 and 0x1B0 for master 1, and k is the block number 1..7. The offsets are: status 0x00, clear 0x01, mask 0x08, live 0x0F. Because the status and clear ranges overlap, a read of an overlapping address returns status. A read of base+8, or of any address outside both windows (base..base+22), returns 0x00.
- R4: Source number n = (m*7 + k - 1)*8 + b is bit b of block k in master m.
- R5: A mask bit set to 1 hides its source from the status read, the summary and `irq_o`. A masked source still latches edges, and it becomes visible once it is unmasked. Mask registers read back the value written.
- R6: Writing 1 to a bit of a clear register clears that source's latch. Bits written as 0 leave their sources unchanged.
- R7: When a clear write and a new rising edge of the same source fall on the same clock edge, the source stays pending.
- R8: The live-level register returns the synchronised levels of the block's 8 inputs, whatever the mask.
- R9: In master m's summary, bit k is the OR of block k's unmasked pending bits. Master 0's bit 0 is set when master 1 has any unmasked pending bit. Master 1's bit 0 reads 0.
- R10: `irq_o` is a registered OR of all unmasked pending bits of both masters.
- R11: `bus_rdata` shows the register addressed in the previous cycle.
- R12: An input held high does not re-latch after it is cleared. Only a new rising edge sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 112 | Interrupt sources, active high, asynchronous |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe for `bus_addr` / `bus_wdata` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for last cycle's address |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The bench counts edges as follows, starting from the first edge that samples an input high:
- The live level reaches `bus_rdata` after the third edge.
- The latched status and `irq_o` change after the fourth edge.
- A register write takes effect at its own edge, so `irq_o` follows a mask or clear write one edge later.
- A read presents its address at a falling edge and samples `bus_rdata` 1 ns after the next rising edge, which is the point R11 defines.

After each stimulus the bench waits at least five edges before checking, so every result is already settled. The one exception is the coincidence test, which places the clear write on exactly the edge where the rising edge is detected.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // per-block register offsets relative to master base + block number
  localparam int OFS_STAT = 0;
  localparam int OFS_CLR  = 1;
  localparam int OFS_MASK = 8;
  localparam int OFS_LIVE = 15;
endpackage

// File: rtl/irqc_src_block.sv
module irqc_src_block #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] vis,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] live
);
  logic [W-1:0] sync_q [SYNC];
  logic [W-1:0] prev_q, pend_q, rise, clr_bits;

  assign live     = sync_q[SYNC-1];
  assign rise     = sync_q[SYNC-1] & ~prev_q;
  assign clr_bits = clr_we ? wdata : '0;
  assign vis      = pend_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
      prev_q <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      sync_q[0] <= src;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC-1];
      // new edge wins over a coinciding clear (R7)
      pend_q <= (pend_q & ~clr_bits) | rise;
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/irqc_master_group.sv
module irqc_master_group
  import irqc_pkg::*;
#(
  parameter int          BLKS = 7,
  parameter int          W    = 8,
  parameter int          AW   = 16,
  parameter int          SYNC = 2,
  parameter logic [AW-1:0] BASE = 16'h0130
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BLKS*W-1:0] src,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [W-1:0]    wdata,
  input  logic            casc,
  output logic            any,
  output logic [W-1:0]    rdata
);
  localparam int SPAN = BLKS + OFS_LIVE + 1;

  logic [AW-1:0]   off;
  logic            in_win;
  logic [BLKS-1:0] clr_we, mask_we, blk_any;
  logic [W-1:0]    vis  [BLKS];
  logic [W-1:0]    msk  [BLKS];
  logic [W-1:0]    live [BLKS];
  logic [W-1:0]    summ;

  assign off    = addr - BASE;
  assign in_win = (addr >= BASE) && (off < AW'(SPAN));

  for (genvar g = 0; g < BLKS; g++) begin : g_blk
    assign clr_we[g]  = wr && in_win && (off == AW'(g + 1 + OFS_CLR));
    assign mask_we[g] = wr && in_win && (off == AW'(g + 1 + OFS_MASK));
    irqc_src_block #(.W(W), .SYNC(SYNC)) blk_i (
      .clk(clk), .rst(rst), .src(src[g*W +: W]),
      .clr_we(clr_we[g]), .mask_we(mask_we[g]), .wdata(wdata),
      .vis(vis[g]), .mask_q(msk[g]), .live(live[g])
    );
    assign blk_any[g] = |vis[g];
  end

  assign any = |blk_any;

  // summary: bit 0 cascade, bit k block k (R9)
  always_comb begin
    summ    = '0;
    summ[0] = casc;
    for (int k = 0; k < BLKS; k++) summ[k+1] = blk_any[k];
  end

  // read decode; status wins over overlapping clear addresses (R3)
  always_comb begin
    rdata = '0;
    if (in_win) begin
      if (off == AW'(OFS_STAT)) rdata = summ;
      for (int k = 0; k < BLKS; k++) begin
        if (off == AW'(k + 1 + OFS_STAT)) rdata = vis[k];
        if (off == AW'(k + 1 + OFS_MASK)) rdata = msk[k];
        if (off == AW'(k + 1 + OFS_LIVE)) rdata = live[k];
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter int NUM_MASTERS     = 2,
  parameter int BLKS_PER_MASTER = 7,
  parameter int DATA_W          = 8,
  parameter int ADDR_W          = 16,
  parameter int SYNC_STAGES     = 2,
  parameter logic [NUM_MASTERS-1:0][ADDR_W-1:0] MASTER_BASE = {16'h01B0, 16'h0130},
  localparam int SRC_PER_M = BLKS_PER_MASTER * DATA_W,
  localparam int NUM_SRC   = NUM_MASTERS * SRC_PER_M
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  logic [NUM_MASTERS-1:0] grp_any, casc;
  logic [DATA_W-1:0]      grp_rd [NUM_MASTERS];
  logic [DATA_W-1:0]      rd_mux;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
    if (m + 1 < NUM_MASTERS) begin : g_casc
      assign casc[m] = grp_any[m+1];
    end else begin : g_last
      assign casc[m] = 1'b0;
    end
    irqc_master_group #(
      .BLKS(BLKS_PER_MASTER), .W(DATA_W), .AW(ADDR_W),
      .SYNC(SYNC_STAGES), .BASE(MASTER_BASE[m])
    ) grp_i (
      .clk(clk), .rst(rst), .src(src_i[m*SRC_PER_M +: SRC_PER_M]),
      .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .casc(casc[m]), .any(grp_any[m]), .rdata(grp_rd[m])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int m = 0; m < NUM_MASTERS; m++) rd_mux = rd_mux | grp_rd[m];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;      // R11
      irq_o     <= |grp_any;    // R10
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int          AW    = 16,
  parameter int          W     = 8,
  parameter logic [AW-1:0] BASE0 = 16'h0130,
  parameter logic [AW-1:0] BASE1 = 16'h01B0
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic          irq_o
);
  localparam logic [AW-1:0] CLR7_0 = BASE0 + AW'(8);
  localparam logic [AW-1:0] CLR7_1 = BASE1 + AW'(8);
  localparam logic [AW-1:0] MLO0 = BASE0 + AW'(9);
  localparam logic [AW-1:0] MHI0 = BASE0 + AW'(15);
  localparam logic [AW-1:0] MLO1 = BASE1 + AW'(9);
  localparam logic [AW-1:0] MHI1 = BASE1 + AW'(15);

  logic is_mask, is_outside;
  assign is_mask = (bus_addr >= MLO0 && bus_addr <= MHI0) ||
                   (bus_addr >= MLO1 && bus_addr <= MHI1);
  assign is_outside = (bus_addr < BASE0) ||
                      (bus_addr > BASE0 + AW'(22) && bus_addr < BASE1) ||
                      (bus_addr > BASE1 + AW'(22));

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_o && bus_rdata == '0)); // R1
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == CLR7_0 || bus_addr == CLR7_1) |=> bus_rdata == '0); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    is_outside |=> bus_rdata == '0); // R3
  AST_LAST_CASCADE_LOW: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == BASE1) |=> !bus_rdata[0]); // R9
  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_mask) ##1 (!bus_wr && $stable(bus_addr)) |=> bus_rdata == $past(bus_wdata, 2)); // R5
endmodule

bind irq_cascade_ctrl irqc_checker #(
  .AW(ADDR_W), .W(DATA_W), .BASE0(MASTER_BASE[0]), .BASE1(MASTER_BASE[1])
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
);

// File: tb/irq_cascade_ctrl_tb_top.sv
module irq_cascade_ctrl_tb_top;
  localparam int NS = 112;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [NS-1:0] src;
  logic [15:0]   addr;
  logic          wr;
  logic [7:0]    wdata, rdata, d;
  logic          irq;
  int checks = 0, fails = 0;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ra(input int m, input int k, input int off);
    return (m == 0 ? 16'h0130 : 16'h01B0) + 16'(k + off);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #1 v = rdata;
  endtask

  task automatic wrr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; src = '0; addr = '0; wr = 1'b0; wdata = '0;
    cyc(4);
    @(negedge clk) rst = 1'b0;
    cyc(1);
    chk("R1 irq after reset", 32'(irq), 0);
    for (int m = 0; m < 2; m++)
      for (int k = 1; k <= 7; k++) begin
        rd(ra(m, k, 8), d);  chk("R1 mask reset", 32'(d), 32'hFF);
        rd(ra(m, k, 0), d);  chk("R1 status reset", 32'(d), 0);
      end
    for (int m = 0; m < 2; m++)
      for (int k = 1; k <= 7; k++) wrr(ra(m, k, 8), 8'h00);

    // R11: data shows one edge after the address
    wrr(ra(0, 1, 8), 8'h5A);
    @(negedge clk); addr = ra(0, 1, 8);
    @(posedge clk); #1 chk("R11 read latency", 32'(rdata), 32'h5A);
    wrr(ra(0, 1, 8), 8'h00);

    // sweep every source: R2 R4 R8 R9 R10 R6
    for (int s = 0; s < NS; s++) begin
      int m, k, b;
      m = s / 56; k = (s % 56) / 8 + 1; b = s % 8;
      @(negedge clk) src[s] = 1'b1;
      cyc(5);
      chk("R10 irq on source", 32'(irq), 1);
      rd(ra(m, k, 15), d); chk("R8 live level", 32'(d), 32'(1 << b));
      rd(ra(m, k, 0), d);  chk("R2 R4 latched status", 32'(d), 32'(1 << b));
      rd(ra(0, 0, 0), d);  chk("R9 master0 summary", 32'(d), (m == 0) ? 32'(1 << k) : 1);
      rd(ra(1, 0, 0), d);  chk("R9 master1 summary", 32'(d), (m == 1) ? 32'(1 << k) : 0);
      @(negedge clk) src[s] = 1'b0;
      wrr(ra(m, k, 1), 8'(1 << b));
      cyc(2);
      chk("R6 irq after clear", 32'(irq), 0);
      rd(ra(m, k, 0), d);  chk("R6 status after clear", 32'(d), 0);
    end

    // R12: held level does not re-latch
    @(negedge clk) src[9] = 1'b1;
    cyc(5);
    wrr(ra(0, 2, 1), 8'h02);
    cyc(4);
    rd(ra(0, 2, 0), d); chk("R12 held level no relatch", 32'(d), 0);
    chk("R12 irq stays low", 32'(irq), 0);
    @(negedge clk) src[9] = 1'b0;
    cyc(4);

    // R6 partial clear
    @(negedge clk) begin src[24+2] = 1'b1; src[24+5] = 1'b1; end
    cyc(5);
    @(negedge clk) begin src[24+2] = 1'b0; src[24+5] = 1'b0; end
    wrr(ra(0, 4, 1), 8'h04);
    rd(ra(0, 4, 0), d); chk("R6 partial clear", 32'(d), 32'h20);
    wrr(ra(0, 4, 1), 8'h20);

    // R5 mask hides but keeps latching
    wrr(ra(1, 3, 8), 8'hFF);
    @(negedge clk) src[76] = 1'b1;
    cyc(5);
    chk("R5 masked irq", 32'(irq), 0);
    rd(ra(1, 3, 0), d);  chk("R5 masked status", 32'(d), 0);
    rd(ra(0, 0, 0), d);  chk("R5 masked summary", 32'(d), 0);
    rd(ra(1, 3, 15), d); chk("R8 live while masked", 32'(d), 32'h10);
    @(negedge clk) src[76] = 1'b0;
    wrr(ra(1, 3, 8), 8'h00);
    cyc(2);
    chk("R5 irq after unmask", 32'(irq), 1);
    rd(ra(1, 3, 0), d);  chk("R5 status after unmask", 32'(d), 32'h10);
    rd(ra(0, 0, 0), d);  chk("R9 cascade bit", 32'(d), 1);
    wrr(ra(1, 3, 1), 8'h10);

    // R7: clear on the same edge as a new rising edge
    @(negedge clk) src[0] = 1'b1;
    cyc(5);
    @(negedge clk) src[0] = 1'b0;
    cyc(4);
    @(negedge clk) src[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); addr = ra(0, 1, 1); wdata = 8'h01; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
    rd(ra(0, 1, 0), d); chk("R7 edge beats clear", 32'(d), 1);
    @(negedge clk) src[0] = 1'b0;
    wrr(ra(0, 1, 1), 8'h01);

    // R3: clear-only and unmapped addresses read zero; overlap reads status
    @(negedge clk) src[48] = 1'b1;
    cyc(5);
    rd(ra(0, 7, 1), d);   chk("R3 clear addr reads zero", 32'(d), 0);
    rd(16'h0000, d);      chk("R3 unmapped low", 32'(d), 0);
    rd(ra(1, 0, 23), d);  chk("R3 past window", 32'(d), 0);
    rd(ra(0, 7, 0), d);   chk("R3 block7 status", 32'(d), 1);
    @(negedge clk) src[48] = 1'b0;
    @(negedge clk) src[8] = 1'b1;
    cyc(5);
    rd(ra(0, 1, 1), d);   chk("R3 overlap reads status", 32'(d), 1);
    @(negedge clk) src[8] = 1'b0;
    wrr(ra(0, 2, 1), 8'h01);
    wrr(ra(0, 7, 1), 8'h01);
    cyc(2);
    chk("R10 irq idle at end", 32'(irq), 0);

    finish_run();
  end
endmodule